// File: doc/BRIEF.md
# Single-Precision Rounding Stage with Selectable Rounding Mode

This block is the last step of a floating-point add or multiply pipeline. It takes an unrounded single-precision result: a sign, a biased 8-bit exponent and a 24-bit significand with the leading bit written out. It also takes the guard, round and sticky bits that the upstream datapath kept from the bits it dropped. The block returns the packed 32-bit result, rounded under the rounding mode that applies to that instruction. In the first cycle it decides whether the truncated significand or the significand plus one is correct. In the second cycle it applies that choice, handles a carry out of the significand, and packs the word. A result therefore appears exactly two cycles after it is accepted, and one result can be accepted every cycle.

Each instruction either names its own rounding mode or defers to a global mode register held inside the block. Writes to that register come from an older instruction that is still in flight. An instruction that defers to the global mode is held at the input while that write is pending, and also during the cycle in which the write lands. As a result it always sees the updated value. Instructions that name their own mode are never held.

Top module: `fp_round_stage`

## Requirements
- R1: A transaction is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its result appears with `out_valid` = 1 exactly two rising edges later. Back-to-back accepted transactions give back-to-back results. After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The mode codes on `in_rm` are: 000 nearest with ties to even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, and 111 use the global mode register. The result word is {sign, exponent[7:0], fraction[22:0]}.
- R3: In nearest-even mode the significand is incremented exactly when G = 1 and at least one of R, S or the significand LSB is 1. An exact tie therefore rounds to the even value.
- R4: In toward-zero mode the significand is never incremented. The output fraction equals the input significand bits [22:0].
- R5: In toward-plus-infinity mode the significand is incremented when the sign is 0 and any of G, R, S is 1. In toward-minus-infinity mode it is incremented when the sign is 1 and any of G, R, S is 1.
- R6: If the increment carries out of the 24-bit significand, the significand becomes 1.0 (0x800000) and the exponent rises by one. If the exponent is 0 and the rounded significand has bit 23 set, the exponent becomes 1, which turns a subnormal into the smallest normal value.
- R7: If a carry lifts the exponent to 255, the output is a correctly signed infinity (exponent 255, fraction 0) and `out_overflow` is 1. Otherwise `out_overflow` is 0.
- R8: `out_inexact` is 1 exactly when any of G, R or S of that transaction was 1.
- R9: If the effective mode is 100, 101, 110, or 111 read from the global register, `out_illegal` is 1, the result is truncated, and `out_overflow` is 0.
- R10: The global mode register resets to 000. When `gm_we` is 1 on a rising edge, the register takes the value of `gm_wdata`. A transaction with `in_rm` = 111 is rounded with the register value that holds when it is accepted.
- R11: `in_ready` is 0 whenever `in_rm` = 111 and either `gm_busy` or `gm_we` is 1. In every other case `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Unrounded operand present |
| in_ready | output | 1 | Stage can accept this cycle |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | 8 | Biased exponent, 0 for subnormal |
| in_sig | input | 24 | Significand with explicit leading bit |
| in_grd | input | 1 | Guard bit |
| in_rnd | input | 1 | Round bit |
| in_stk | input | 1 | Sticky bit |
| in_rm | input | 3 | Rounding mode code of this instruction |
| gm_busy | input | 1 | An older in-flight instruction will write the global mode |
| gm_we | input | 1 | Global mode write strobe |
| gm_wdata | input | 3 | Global mode value to write |
| out_valid | output | 1 | Rounded result present |
| out_word | output | 32 | Packed single-precision result |
| out_inexact | output | 1 | Discarded bits were non-zero |
| out_overflow | output | 1 | Rounding overflowed to infinity |
| out_illegal | output | 1 | Effective mode code was not legal |

## Verification
A wrong increment decision in the first register stage shows up two cycles after acceptance, as an output word off by one unit in the last place. Tie cases and sign-directed cases bring out such errors, because their inputs differ only in a bit that the decision depends on. A corrupt global mode register leaves the per-instruction modes unaffected. It shows up on the first later transaction with code 111, again two cycles after acceptance. A broken interlock shows up within the same cycle as `in_ready` being high while a write is pending, or as a global-mode result that was rounded with the old mode. A wrong carry or overflow path shows only on all-ones significands, so those inputs are driven at the normal, maximum-exponent and subnormal boundaries.

// File: rtl/fp_round_stage.sv
module fp_round_stage #(
  parameter int EXP_W = 8,
  parameter int SIG_W = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_sign,
  input  logic [EXP_W-1:0]       in_exp,
  input  logic [SIG_W-1:0]       in_sig,
  input  logic                   in_grd,
  input  logic                   in_rnd,
  input  logic                   in_stk,
  input  logic [2:0]             in_rm,
  input  logic                   gm_busy,
  input  logic                   gm_we,
  input  logic [2:0]             gm_wdata,
  output logic                   out_valid,
  output logic [EXP_W+SIG_W-1:0] out_word,
  output logic                   out_inexact,
  output logic                   out_overflow,
  output logic                   out_illegal
);
  localparam int FRAC_W = SIG_W - 1;
  localparam int WORD_W = EXP_W + SIG_W;
  localparam logic [2:0] RM_NE = 3'b000;
  localparam logic [2:0] RM_TZ = 3'b001;
  localparam logic [2:0] RM_DN = 3'b010;
  localparam logic [2:0] RM_UP = 3'b011;
  localparam logic [2:0] RM_GL = 3'b111;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_TOP = {{(EXP_W-1){1'b1}}, 1'b0};
  localparam logic [EXP_W-1:0] EXP_ONE = {{(EXP_W-1){1'b0}}, 1'b1};

  // global mode register and hazard interlock
  logic [2:0] gmode;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     gmode <= RM_NE;
    else if (gm_we) gmode <= gm_wdata;

  wire       use_glb = (in_rm == RM_GL);
  assign     in_ready = !(use_glb && (gm_busy || gm_we));
  wire       take = in_valid && in_ready;
  wire [2:0] eff  = use_glb ? gmode : in_rm;
  wire       lost = in_grd | in_rnd | in_stk;

  // stage 1: choose between truncated and incremented candidates
  logic inc_sel;
  always_comb begin
    case (eff)
      RM_NE:   inc_sel = in_grd & (in_rnd | in_stk | in_sig[0]);
      RM_TZ:   inc_sel = 1'b0;
      RM_DN:   inc_sel = in_sign & lost;
      RM_UP:   inc_sel = ~in_sign & lost;
      default: inc_sel = 1'b0;
    endcase
  end

  logic             v1, s1_sign, s1_inc, s1_inx, s1_ill;
  logic [EXP_W-1:0] s1_exp;
  logic [SIG_W-1:0] s1_sig;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; s1_sign <= 1'b0; s1_inc <= 1'b0; s1_inx <= 1'b0; s1_ill <= 1'b0;
      s1_exp <= '0; s1_sig <= '0;
    end else begin
      v1 <= take;
      if (take) begin
        s1_sign <= in_sign;
        s1_exp  <= in_exp;
        s1_sig  <= in_sig;
        s1_inc  <= inc_sel;
        s1_inx  <= lost;
        s1_ill  <= eff[2];
      end
    end
  end

  // stage 2: candidate mux, carry renormalisation, overflow, packing
  wire [SIG_W:0]   cand_up = {1'b0, s1_sig} + {{SIG_W{1'b0}}, 1'b1};
  wire [SIG_W:0]   picked  = s1_inc ? cand_up : {1'b0, s1_sig};
  wire             carry   = picked[SIG_W];
  wire [SIG_W-1:0] rsig    = carry ? picked[SIG_W:1] : picked[SIG_W-1:0];
  wire [EXP_W-1:0] rexp    = (s1_exp == '0 && rsig[SIG_W-1]) ? EXP_ONE
                             : s1_exp + {{(EXP_W-1){1'b0}}, carry};
  wire             ovf     = carry && (s1_exp == EXP_TOP);
  wire [WORD_W-1:0] packed_w = ovf ? {s1_sign, EXP_MAX, {FRAC_W{1'b0}}}
                                   : {s1_sign, rexp, rsig[FRAC_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_word <= '0;
      out_inexact <= 1'b0; out_overflow <= 1'b0; out_illegal <= 1'b0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_word     <= packed_w;
        out_inexact  <= s1_inx;
        out_overflow <= ovf;
        out_illegal  <= s1_ill;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##2 out_valid);

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rm == RM_GL && (gm_busy || gm_we)) |-> !in_ready);

  p_nostall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rm != RM_GL) |-> in_ready);

  p_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##2 (out_inexact == $past(in_grd | in_rnd | in_stk, 2)));

  p_trunc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_rm == RM_TZ) |-> ##2
      (out_word[FRAC_W-1:0] == $past(in_sig[FRAC_W-1:0], 2)));

  p_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> (out_word[WORD_W-2:0] == {EXP_MAX, {FRAC_W{1'b0}}}));

  p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_rm[2] && in_rm != RM_GL) |-> ##2 (out_illegal && !out_overflow));
endmodule

// File: tb/fp_round_stage_bench.sv
`timescale 1ns/1ps
module fp_round_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic        in_sign = 1'b0;
  logic [7:0]  in_exp = '0;
  logic [23:0] in_sig = '0;
  logic        in_grd = 1'b0, in_rnd = 1'b0, in_stk = 1'b0;
  logic [2:0]  in_rm = '0;
  logic        gm_busy = 1'b0, gm_we = 1'b0;
  logic [2:0]  gm_wdata = '0;
  logic        out_valid, out_inexact, out_overflow, out_illegal;
  logic [31:0] out_word;

  always #2.5 clk = ~clk;

  fp_round_stage u_fp_round_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
    .in_grd(in_grd), .in_rnd(in_rnd), .in_stk(in_stk), .in_rm(in_rm),
    .gm_busy(gm_busy), .gm_we(gm_we), .gm_wdata(gm_wdata),
    .out_valid(out_valid), .out_word(out_word), .out_inexact(out_inexact),
    .out_overflow(out_overflow), .out_illegal(out_illegal));

  typedef struct packed {
    logic [3:0]  req;
    logic        sgn;
    logic [7:0]  e;
    logic [23:0] m;
    logic [2:0]  grs;
    logic [2:0]  rm;
    logic [31:0] w;
    logic        inx, ovf, ill;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd8, 1'b0, 8'h80, 24'h800000, 3'b000, 3'd0, 32'h40000000, 1'b0, 1'b0, 1'b0}, // R8 exact
    '{4'd3, 1'b0, 8'h80, 24'h800000, 3'b100, 3'd0, 32'h40000000, 1'b1, 1'b0, 1'b0}, // R3 tie, even stays
    '{4'd3, 1'b0, 8'h80, 24'h800001, 3'b100, 3'd0, 32'h40000002, 1'b1, 1'b0, 1'b0}, // R3 tie, odd rounds up
    '{4'd3, 1'b0, 8'h80, 24'h800000, 3'b101, 3'd0, 32'h40000001, 1'b1, 1'b0, 1'b0}, // R3 above half
    '{4'd3, 1'b0, 8'h80, 24'h800000, 3'b011, 3'd0, 32'h40000000, 1'b1, 1'b0, 1'b0}, // R3 below half
    '{4'd4, 1'b1, 8'h80, 24'h8FFFFF, 3'b111, 3'd1, 32'hC00FFFFF, 1'b1, 1'b0, 1'b0}, // R4 truncate
    '{4'd5, 1'b0, 8'h80, 24'h800000, 3'b001, 3'd3, 32'h40000001, 1'b1, 1'b0, 1'b0}, // R5 up, positive
    '{4'd5, 1'b1, 8'h80, 24'h800000, 3'b001, 3'd3, 32'hC0000000, 1'b1, 1'b0, 1'b0}, // R5 up, negative
    '{4'd5, 1'b1, 8'h80, 24'h800000, 3'b001, 3'd2, 32'hC0000001, 1'b1, 1'b0, 1'b0}, // R5 down, negative
    '{4'd5, 1'b0, 8'h80, 24'h800000, 3'b001, 3'd2, 32'h40000000, 1'b1, 1'b0, 1'b0}, // R5 down, positive
    '{4'd6, 1'b0, 8'h80, 24'hFFFFFF, 3'b110, 3'd0, 32'h40800000, 1'b1, 1'b0, 1'b0}, // R6 carry
    '{4'd7, 1'b0, 8'hFE, 24'hFFFFFF, 3'b101, 3'd0, 32'h7F800000, 1'b1, 1'b1, 1'b0}, // R7 +inf
    '{4'd7, 1'b1, 8'hFE, 24'hFFFFFF, 3'b001, 3'd2, 32'hFF800000, 1'b1, 1'b1, 1'b0}, // R7 -inf
    '{4'd6, 1'b0, 8'h00, 24'h7FFFFF, 3'b110, 3'd0, 32'h00800000, 1'b1, 1'b0, 1'b0}, // R6 subnormal promotes
    '{4'd6, 1'b0, 8'h00, 24'h000001, 3'b100, 3'd0, 32'h00000002, 1'b1, 1'b0, 1'b0}, // R6 stays subnormal
    '{4'd9, 1'b0, 8'h80, 24'h800001, 3'b111, 3'd4, 32'h40000001, 1'b1, 1'b0, 1'b1}, // R9 illegal code
    '{4'd2, 1'b0, 8'h80, 24'h800003, 3'b000, 3'd3, 32'h40000003, 1'b0, 1'b0, 1'b0}  // R2 exact, no change
  };

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic [7:0] e, input logic [23:0] m,
                       input logic [2:0] grs, input logic [2:0] rm);
    in_valid = v; in_sign = s; in_exp = e; in_sig = m;
    {in_grd, in_rnd, in_stk} = grs; in_rm = rm;
  endtask

  task automatic expect_out(input string req, input logic [31:0] w, input logic ill);
    check(out_valid == 1'b1, req, {31'd0, out_valid}, 32'd1);
    check(out_word == w, req, out_word, w);
    check(out_illegal == ill, req, {31'd0, out_illegal}, {31'd0, ill});
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R11 after reset", {31'd0, in_ready}, 32'd1);

    // table, one vector per cycle (R1 throughput)
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        vec_t x;
        x = VECS[i-2];
        check(out_valid == 1'b1, $sformatf("R1 vec%0d", i-2), {31'd0, out_valid}, 32'd1);
        check(out_word == x.w, $sformatf("R%0d vec%0d word", x.req, i-2), out_word, x.w);
        check(out_inexact == x.inx, $sformatf("R8 vec%0d", i-2), {31'd0, out_inexact}, {31'd0, x.inx});
        check(out_overflow == x.ovf, $sformatf("R7 vec%0d", i-2), {31'd0, out_overflow}, {31'd0, x.ovf});
        check(out_illegal == x.ill, $sformatf("R9 vec%0d", i-2), {31'd0, out_illegal}, {31'd0, x.ill});
      end
      if (i < NV) drive(1'b1, VECS[i].sgn, VECS[i].e, VECS[i].m, VECS[i].grs, VECS[i].rm);
      else        in_valid = 1'b0;
    end

    // R10: global mode after reset is nearest-even; R1 exact latency
    @(negedge clk);
    drive(1'b1, 1'b0, 8'h80, 24'h800001, 3'b100, 3'd7);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R1 one cycle after accept", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    expect_out("R10 reset global mode", 32'h40000002, 1'b0);

    // R11/R10: write toward-zero while a global-mode instruction waits
    @(negedge clk);
    gm_we = 1'b1; gm_wdata = 3'd1;
    drive(1'b1, 1'b0, 8'h80, 24'h800000, 3'b110, 3'd7);
    #1 check(in_ready == 1'b0, "R11 stall on write", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    gm_we = 1'b0;
    #1 check(in_ready == 1'b1, "R11 release", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    expect_out("R10 global toward zero", 32'h40000000, 1'b0);

    // R11: pending writer holds global-mode instructions only
    @(negedge clk);
    gm_busy = 1'b1;
    drive(1'b1, 1'b0, 8'h80, 24'h800000, 3'b001, 3'd7);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R11 busy stall", {31'd0, in_ready}, 32'd0);
      check(out_valid == 1'b0, "R11 nothing issued", {31'd0, out_valid}, 32'd0);
    end
    in_rm = 3'd0;
    #1 check(in_ready == 1'b1, "R11 own mode not held", {31'd0, in_ready}, 32'd1);
    in_valid = 1'b0; in_rm = 3'd7;
    @(negedge clk);
    gm_we = 1'b1; gm_wdata = 3'd3; in_valid = 1'b1;
    @(negedge clk);
    gm_we = 1'b0; gm_busy = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    expect_out("R10 global toward plus inf", 32'h40000001, 1'b0);

    // R9: illegal code held in the global register
    @(negedge clk);
    gm_we = 1'b1; gm_wdata = 3'd6;
    @(negedge clk);
    gm_we = 1'b0;
    drive(1'b1, 1'b0, 8'h80, 24'h800000, 3'b111, 3'd7);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    expect_out("R9 illegal global", 32'h40000000, 1'b1);
    check(out_overflow == 1'b0, "R9 no overflow", {31'd0, out_overflow}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule